// File: doc/BRIEF.md
# Branch Decode and Target Unit

This block takes one 32-bit instruction word and works out whether it is a branch and, if so, where it goes. It handles four families: PC-relative branches with short or long displacement, the gateway branch, register-indexed and vectored branches through general registers, and external branches that add a displacement to a base register. Alongside the instruction the caller supplies the offset of the instruction itself and the values already read from the two register fields, base (bits [25:21]) and index (bits [20:16]).

One cycle after `in_valid`, the registered result appears:
- a strobe and a branch-valid flag;
- the target address;
- the link register index, its enable and the value to write to it;
- the nullify flag for the following instruction;
- an illegal-encoding flag.

Bits are numbered with bit 0 as the least significant. A pipeline front end uses the result to redirect fetch and to schedule the link write-back.

Top module: `br_decode_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears to zero, whatever the inputs.
- R2: Outputs update one clock after the inputs are sampled. `out_strobe` equals the previous cycle's `in_valid`. When `in_valid` was low, `br_valid`, `illegal`, `link_en` and `nullify` are 0 and `target`, `link_idx` and `link_val` are zero; the same zeros apply to the data outputs whenever `br_valid` is 0.
- R3: The major opcode is `insn[31:26]`. Any major opcode other than 0x38, 0x39 or 0x3A gives `br_valid`=0 and `illegal`=0.
- R4: Major opcodes 0x38 and 0x39 are external branches, always legal. The target is `base_val` + disp17, except when the base field `insn[25:21]` is 0: the target is then disp17 alone and `base_val` is ignored. Opcode 0x38 does not link. Opcode 0x39 links to register 31.
- R5: disp17 is built as follows. Take the 17-bit field {`insn[0]`, `insn[20:16]`, `insn[2]`, `insn[12:3]`}, with `insn[0]` as the most significant bit. Sign-extend it and multiply by 4.
- R6: Under opcode 0x3A the sub-opcode is `insn[15:13]`. Values 000, 100 (short branch) and 001 (gateway) have target `cur_off` + 8 + disp17, and their link index is `insn[25:21]`.
- R7: Sub-opcode 101 is the long branch. Its target is `cur_off` + 8 + disp22, where disp22 is {`insn[0]`, `insn[25:16]`, `insn[2]`, `insn[12:3]`} sign-extended and multiplied by 4. It links to register 2.
- R8: Sub-opcode 010 is the indexed branch, legal only when `insn[12:2]` and `insn[0]` are all zero. Its target is (`index_val` << 3) + `cur_off` + 8, and it links to `insn[25:21]`.
- R9: Sub-opcode 110 with `insn[12:2]`=0 and `insn[0]`=0 is the vectored branch, which never links. Its target is `base_val` + (`index_val` << 3), or `base_val` alone when the index field `insn[20:16]` is 0.
- R10: The vectored-external form requires `insn[12:2]` = 11'b100_0000_0000 and `insn[20:16]` = 0; `insn[0]` is free. It targets `base_val`. With sub-opcode 110 it does not link; with sub-opcode 111 it links to register 2.
- R11: Under opcode 0x3A, each of the following raises `illegal` with `br_valid`, `link_en` and `nullify` all 0: sub-opcode 011; reserved-bit patterns other than those in R8–R10 for sub-opcodes 010, 110 and 111.
- R12: For a valid branch, `nullify` equals `insn[1]`.
- R13: `link_val` = `cur_off` + 8, wrapping modulo 2^32. `link_en` is 1 only for a valid branch whose link index is non-zero. When `link_en` is 0, `link_idx` and `link_val` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| cur_off | input | XLEN | Offset of this instruction |
| base_val | input | XLEN | Value of register named by bits [25:21] |
| index_val | input | XLEN | Value of register named by bits [20:16] |
| out_strobe | output | 1 | Registered copy of in_valid |
| br_valid | output | 1 | Legal branch decoded |
| illegal | output | 1 | Reserved branch encoding |
| target | output | XLEN | Branch target address |
| link_idx | output | 5 | Link register index |
| link_en | output | 1 | Link write requested |
| link_val | output | XLEN | Return address to write |
| nullify | output | 1 | Nullify-next flag |

## Verification
The bench builds the unit with its defaults: XLEN of 32, a link offset of 8 and an index shift of 3. At that width, offsets close to 2^32 make the return address and the relative targets wrap, and sign bit 0 drives displacements across their full negative range. Random words concentrated on the three branch opcodes, with reserved fields often forced to their legal patterns, reach each variant as well as its illegal neighbours. Non-zero `index_val` and `base_val` are supplied in the cases where the field rules say those values must be ignored.

// File: rtl/br_pkg.sv
// Shared encodings for the branch decode unit.
// Assumes bit 0 is the least significant instruction bit.
package br_pkg;
    localparam logic [5:0] OP_EXT      = 6'h38;
    localparam logic [5:0] OP_EXT_LINK = 6'h39;
    localparam logic [5:0] OP_GROUP    = 6'h3A;
    localparam logic [10:0] VEXT_MID   = 11'b100_0000_0000;
    localparam logic [4:0] LINK_RET31  = 5'd31;
    localparam logic [4:0] LINK_RET2   = 5'd2;
    localparam int SHORT_HI_W = 5;
    localparam int LONG_HI_W  = 10;

    typedef enum logic [3:0] {
        BK_NONE, BK_EXT, BK_SHORT, BK_GATE, BK_LONG,
        BK_INDEXED, BK_VEC, BK_VEXT, BK_ILLEGAL
    } br_kind_e;

    typedef struct packed {
        br_kind_e   kind;
        logic [4:0] link;
        logic       nul;
    } br_dec_t;
endpackage

// File: rtl/br_classify.sv
// Combinational classifier: maps an instruction word to a branch kind,
// a link register index and the nullify bit. Reserved patterns give BK_ILLEGAL.
module br_classify
    import br_pkg::*;
(
    input  logic [31:0] insn,
    output br_dec_t     dec
);
    logic [5:0]  major;
    logic [4:0]  fld_b;
    logic [4:0]  fld_x;
    logic [2:0]  sub;
    logic [10:0] mid;
    logic        plain_ok;

    assign major    = insn[31:26];
    assign fld_b    = insn[25:21];
    assign fld_x    = insn[20:16];
    assign sub      = insn[15:13];
    assign mid      = insn[12:2];
    assign plain_ok = (mid == '0) && !insn[0];

    // Decode major opcode and sub-opcode into a kind and link index
    always_comb begin
        dec.kind = BK_NONE;
        dec.link = '0;
        dec.nul  = insn[1];
        unique case (major)
            OP_EXT:      dec.kind = BK_EXT;
            OP_EXT_LINK: begin
                dec.kind = BK_EXT;
                dec.link = LINK_RET31;
            end
            OP_GROUP: begin
                unique case (sub)
                    3'b000, 3'b100: begin
                        dec.kind = BK_SHORT;
                        dec.link = fld_b;
                    end
                    3'b001: begin
                        dec.kind = BK_GATE;
                        dec.link = fld_b;
                    end
                    3'b101: begin
                        dec.kind = BK_LONG;
                        dec.link = LINK_RET2;
                    end
                    3'b010: begin
                        if (plain_ok) begin
                            dec.kind = BK_INDEXED;
                            dec.link = fld_b;
                        end else begin
                            dec.kind = BK_ILLEGAL;
                        end
                    end
                    3'b110: begin
                        if (mid == VEXT_MID && fld_x == '0) dec.kind = BK_VEXT;
                        else if (plain_ok)                   dec.kind = BK_VEC;
                        else                                 dec.kind = BK_ILLEGAL;
                    end
                    3'b111: begin
                        if (mid == VEXT_MID && fld_x == '0) begin
                            dec.kind = BK_VEXT;
                            dec.link = LINK_RET2;
                        end else begin
                            dec.kind = BK_ILLEGAL;
                        end
                    end
                    default: dec.kind = BK_ILLEGAL;
                endcase
            end
            default: dec.kind = BK_NONE;
        endcase
    end
endmodule

// File: rtl/br_disp_gen.sv
// Rebuilds the short and long displacements from scattered fields.
// Slot 0 is the short form, slot 1 the long form; both are sign-extended
// from the word's bit 0 and scaled by 4. Assumes XLEN >= 26.
module br_disp_gen
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [9:0]            hi_field,
    input  logic [10:0]           mid_field,
    input  logic                  sign_bit,
    output logic [1:0][XLEN-1:0]  disp
);
    for (genvar g = 0; g < 2; g++) begin : g_form
        localparam int HW    = (g == 0) ? SHORT_HI_W : LONG_HI_W;
        localparam int RAW_W = HW + 12;
        localparam int EXT_W = XLEN - RAW_W - 2;
        logic [RAW_W-1:0] raw;
        // Concatenate sign, high field, bit 2, bits [12:3]
        assign raw = {sign_bit, hi_field[HW-1:0], mid_field[0], mid_field[10:1]};
        assign disp[g] = {{EXT_W{sign_bit}}, raw, 2'b00};
    end
endmodule

// File: rtl/br_target_calc.sv
// Selects the target arithmetic for the decoded branch kind.
// Assumes register values arrive already read for the base and index fields.
module br_target_calc
    import br_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int LINK_OFF  = 8,
    parameter int IDX_SHIFT = 3
) (
    input  br_kind_e             kind,
    input  logic                 b_zero,
    input  logic                 x_zero,
    input  logic [XLEN-1:0]      cur_off,
    input  logic [XLEN-1:0]      base_val,
    input  logic [XLEN-1:0]      index_val,
    input  logic [1:0][XLEN-1:0] disp,
    output logic [XLEN-1:0]      target,
    output logic [XLEN-1:0]      next_off
);
    localparam logic [XLEN-1:0] OFF_STEP = XLEN'(LINK_OFF);
    logic [XLEN-1:0] scaled_idx;

    assign next_off   = cur_off + OFF_STEP;
    assign scaled_idx = index_val << IDX_SHIFT;

    // Per-kind target arithmetic
    always_comb begin
        unique case (kind)
            BK_EXT:           target = b_zero ? disp[0] : base_val + disp[0];
            BK_SHORT, BK_GATE: target = next_off + disp[0];
            BK_LONG:          target = next_off + disp[1];
            BK_INDEXED:       target = scaled_idx + next_off;
            BK_VEC:           target = x_zero ? base_val : base_val + scaled_idx;
            BK_VEXT:          target = base_val;
            default:          target = '0;
        endcase
    end
endmodule

// File: rtl/br_decode_unit.sv
// Top of the branch decode unit: classifies the word, forms displacements,
// computes target and link, and registers everything one cycle after in_valid.
// Assumes base_val/index_val belong to fields [25:21]/[20:16] of insn.
module br_decode_unit
    import br_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int LINK_OFF  = 8,
    parameter int IDX_SHIFT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] cur_off,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    output logic            out_strobe,
    output logic            br_valid,
    output logic            illegal,
    output logic [XLEN-1:0] target,
    output logic [4:0]      link_idx,
    output logic            link_en,
    output logic [XLEN-1:0] link_val,
    output logic            nullify
);
    br_dec_t              dec;
    logic [1:0][XLEN-1:0] disp;
    logic [XLEN-1:0]      tgt_c;
    logic [XLEN-1:0]      next_off;
    logic                 is_br;
    logic                 is_ill;
    logic                 do_link;

    br_classify u_cls (
        .insn (insn),
        .dec  (dec)
    );

    br_disp_gen #(.XLEN(XLEN)) u_disp (
        .hi_field  (insn[25:16]),
        .mid_field (insn[12:2]),
        .sign_bit  (insn[0]),
        .disp      (disp)
    );

    br_target_calc #(
        .XLEN(XLEN), .LINK_OFF(LINK_OFF), .IDX_SHIFT(IDX_SHIFT)
    ) u_tgt (
        .kind      (dec.kind),
        .b_zero    (insn[25:21] == 5'd0),
        .x_zero    (insn[20:16] == 5'd0),
        .cur_off   (cur_off),
        .base_val  (base_val),
        .index_val (index_val),
        .disp      (disp),
        .target    (tgt_c),
        .next_off  (next_off)
    );

    assign is_br   = in_valid && (dec.kind != BK_NONE) && (dec.kind != BK_ILLEGAL);
    assign is_ill  = in_valid && (dec.kind == BK_ILLEGAL);
    assign do_link = is_br && (dec.link != 5'd0);

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_strobe <= 1'b0;
            br_valid   <= 1'b0;
            illegal    <= 1'b0;
            target     <= '0;
            link_idx   <= '0;
            link_en    <= 1'b0;
            link_val   <= '0;
            nullify    <= 1'b0;
        end else begin
            out_strobe <= in_valid;
            br_valid   <= is_br;
            illegal    <= is_ill;
            target     <= is_br ? tgt_c : '0;
            link_idx   <= do_link ? dec.link : 5'd0;
            link_en    <= do_link;
            link_val   <= do_link ? next_off : '0;
            nullify    <= is_br && dec.nul;
        end
    end
endmodule

// File: rtl/br_decode_unit_chk.sv
// Temporal checks on the branch decode unit, bound to every instance.
module br_decode_unit_chk #(
    parameter int XLEN     = 32,
    parameter int LINK_OFF = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [5:0]      major,
    input logic [2:0]      sub,
    input logic [XLEN-1:0] cur_off,
    input logic            out_strobe,
    input logic            br_valid,
    input logic            illegal,
    input logic [4:0]      link_idx,
    input logic            link_en,
    input logic [XLEN-1:0] link_val,
    input logic            nullify
);
    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_strobe);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_strobe && !br_valid && !illegal && !link_en && !nullify));
    // R11
    valid_xor_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_valid && illegal));
    // R11
    sub011_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major == 6'h3A && sub == 3'b011) |=> (illegal && !br_valid));
    // R3
    other_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major != 6'h38 && major != 6'h39 && major != 6'h3A)
        |=> (!br_valid && !illegal));
    // R4
    ext_link31_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major == 6'h39) |=> (link_en && link_idx == 5'd31));
    // R4
    ext_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major == 6'h38) |=> (br_valid && !link_en));
    // R7
    long_link2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major == 6'h3A && sub == 3'b101) |=> (link_en && link_idx == 5'd2));
    // R13
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> (link_val == $past(cur_off) + XLEN'(LINK_OFF)));
    // R13
    link_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> (br_valid && link_idx != 5'd0));
    // R12
    nullify_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> br_valid);
endmodule

bind br_decode_unit br_decode_unit_chk #(.XLEN(XLEN), .LINK_OFF(LINK_OFF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .major      (insn[31:26]),
    .sub        (insn[15:13]),
    .cur_off    (cur_off),
    .out_strobe (out_strobe),
    .br_valid   (br_valid),
    .illegal    (illegal),
    .link_idx   (link_idx),
    .link_en    (link_en),
    .link_val   (link_val),
    .nullify    (nullify)
);

// File: tb/sim_br_decode_unit.sv
module sim_br_decode_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] cur_off = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic        out_strobe, br_valid, illegal, link_en, nullify;
    logic [31:0] target, link_val;
    logic [4:0]  link_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic        stb, bv, ill, len, nul;
        logic [31:0] tgt, lval;
        logic [4:0]  lidx;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    br_decode_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .cur_off(cur_off), .base_val(base_val), .index_val(index_val),
        .out_strobe(out_strobe), .br_valid(br_valid), .illegal(illegal),
        .target(target), .link_idx(link_idx), .link_en(link_en),
        .link_val(link_val), .nullify(nullify)
    );

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] b, logic [4:0] x,
                                       logic [2:0] sub, logic [10:0] mid, logic n, logic s);
        return {op, b, x, sub, mid, n, s};
    endfunction

    // Behavioural reference from the requirements
    function automatic exp_t model(logic v, logic [31:0] w, logic [31:0] off,
                                   logic [31:0] bv, logic [31:0] xv);
        exp_t e;
        longint f17, f22, d17, d22, t;
        int major, sub, mid, lk;
        bit ok, bad;
        e = '{stb: v, bv: 0, ill: 0, len: 0, nul: 0, tgt: 0, lval: 0, lidx: 0, tag: "R2"};
        if (!v) return e;
        major = int'(w >> 26);
        sub   = int'((w >> 13) & 7);
        mid   = int'((w >> 2) & 11'h7FF);
        f17 = longint'(w[20:16]) * 2048 + longint'(w[2]) * 1024 + longint'(w[12:3]);
        if (w[0]) f17 -= 65536;
        d17 = f17 * 4;
        f22 = longint'(w[25:16]) * 2048 + longint'(w[2]) * 1024 + longint'(w[12:3]);
        if (w[0]) f22 -= 2097152;
        d22 = f22 * 4;
        ok = 0; bad = 0; lk = 0; t = 0;
        if (major == 'h38 || major == 'h39) begin
            ok = 1; e.tag = "R4 R5 R12";
            t = (w[25:21] == 0) ? d17 : longint'(bv) + d17;
            lk = (major == 'h39) ? 31 : 0;
        end else if (major == 'h3A) begin
            if (sub == 0 || sub == 4 || sub == 1) begin
                ok = 1; e.tag = "R6 R5 R12"; t = longint'(off) + 8 + d17; lk = int'(w[25:21]);
            end else if (sub == 5) begin
                ok = 1; e.tag = "R7 R12"; t = longint'(off) + 8 + d22; lk = 2;
            end else if (sub == 2) begin
                if (mid == 0 && !w[0]) begin
                    ok = 1; e.tag = "R8 R12"; t = longint'(xv) * 8 + longint'(off) + 8;
                    lk = int'(w[25:21]);
                end else begin bad = 1; e.tag = "R11"; end
            end else if ((sub == 6 || sub == 7) && mid == 'h400 && w[20:16] == 0) begin
                ok = 1; e.tag = "R10 R12"; t = longint'(bv); lk = (sub == 7) ? 2 : 0;
            end else if (sub == 6 && mid == 0 && !w[0]) begin
                ok = 1; e.tag = "R9 R12";
                t = (w[20:16] == 0) ? longint'(bv) : longint'(bv) + longint'(xv) * 8;
            end else begin
                bad = 1; e.tag = "R11";
            end
        end else begin
            e.tag = "R3";
        end
        e.bv = ok; e.ill = bad;
        if (ok) begin
            e.tgt = t[31:0];
            e.nul = w[1];
            if (lk != 0) begin
                e.len = 1; e.lidx = 5'(lk); e.lval = off + 32'd8;
                e.tag = {e.tag, " R13"};
            end
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (out_strobe !== e.stb || br_valid !== e.bv || illegal !== e.ill ||
            target !== e.tgt || link_idx !== e.lidx || link_en !== e.len ||
            link_val !== e.lval || nullify !== e.nul) begin
            failures++;
            $display("FAIL %s: got stb=%b bv=%b ill=%b tgt=%h li=%0d le=%b lv=%h n=%b exp stb=%b bv=%b ill=%b tgt=%h li=%0d le=%b lv=%h n=%b",
                e.tag, out_strobe, br_valid, illegal, target, link_idx, link_en, link_val, nullify,
                e.stb, e.bv, e.ill, e.tgt, e.lidx, e.len, e.lval, e.nul);
        end
    endtask

    task automatic step(logic v, logic [31:0] w, logic [31:0] off,
                        logic [31:0] bv, logic [31:0] xv);
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        in_valid = v; insn = w; cur_off = off; base_val = bv; index_val = xv;
        q.push_back(model(v, w, off, bv, xv));
    endtask

    initial begin
        exp_t z;
        // R1: reset dominates a live branch word
        in_valid = 1'b1;
        insn = mk(6'h39, 5'd3, 5'd1, 3'b000, 11'h155, 1'b1, 1'b0);
        cur_off = 32'h100; base_val = 32'h4000;
        repeat (3) @(negedge clk);
        z = '{stb: 0, bv: 0, ill: 0, len: 0, nul: 0, tgt: 0, lval: 0, lidx: 0, tag: "R1"};
        compare(z);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3: non-branch major opcodes
        step(1, mk(6'h00, 5'd4, 5'd2, 3'b000, 11'h0, 1'b1, 1'b0), 32'h200, 32'h1, 32'h2);
        step(1, mk(6'h3B, 5'd4, 5'd2, 3'b010, 11'h0, 1'b0, 1'b0), 32'h200, 32'h1, 32'h2);
        // R4/R5: external, base field zero ignores base_val, negative disp
        step(1, mk(6'h38, 5'd0, 5'd7, 3'b101, 11'h3FF, 1'b0, 1'b1), 32'h300, 32'hDEAD0000, 32'h9);
        // R4: external with base
        step(1, mk(6'h38, 5'd5, 5'd1, 3'b010, 11'h002, 1'b1, 1'b0), 32'h300, 32'h1000, 32'h0);
        // R4/R13: external linking to 31
        step(1, mk(6'h39, 5'd3, 5'd0, 3'b000, 11'h010, 1'b0, 1'b0), 32'h400, 32'h8000, 32'h0);
        // R2: idle with a branch word present
        step(0, mk(6'h39, 5'd3, 5'd0, 3'b000, 11'h010, 1'b1, 1'b0), 32'h400, 32'h8000, 32'h0);
        // R6: short branch linking to 2, and with link field 0
        step(1, mk(6'h3A, 5'd2, 5'd3, 3'b000, 11'h401, 1'b1, 1'b0), 32'h1000, 32'h0, 32'h0);
        step(1, mk(6'h3A, 5'd0, 5'd31, 3'b100, 11'h7FF, 1'b0, 1'b1), 32'h1000, 32'h0, 32'h0);
        // R6: gateway
        step(1, mk(6'h3A, 5'd9, 5'd0, 3'b001, 11'h020, 1'b0, 1'b0), 32'h2000, 32'h0, 32'h0);
        // R7: long displacement, negative
        step(1, mk(6'h3A, 5'd21, 5'd10, 3'b101, 11'h0C3, 1'b1, 1'b1), 32'h10000, 32'h0, 32'h0);
        // R8: indexed legal, then reserved-bit and bit-0 violations (R11)
        step(1, mk(6'h3A, 5'd7, 5'd4, 3'b010, 11'h000, 1'b1, 1'b0), 32'h500, 32'h0, 32'h30);
        step(1, mk(6'h3A, 5'd7, 5'd4, 3'b010, 11'h100, 1'b0, 1'b0), 32'h500, 32'h0, 32'h30);
        step(1, mk(6'h3A, 5'd7, 5'd4, 3'b010, 11'h000, 1'b1, 1'b1), 32'h500, 32'h0, 32'h30);
        // R9: vectored, index field zero ignores index_val, then indexed
        step(1, mk(6'h3A, 5'd6, 5'd0, 3'b110, 11'h000, 1'b0, 1'b0), 32'h600, 32'h7000, 32'h55);
        step(1, mk(6'h3A, 5'd6, 5'd3, 3'b110, 11'h000, 1'b1, 1'b0), 32'h600, 32'h7000, 32'h55);
        // R10: vectored-external no link and link 2, bit 0 free
        step(1, mk(6'h3A, 5'd8, 5'd0, 3'b110, 11'h400, 1'b0, 1'b1), 32'h700, 32'hABC0, 32'h3);
        step(1, mk(6'h3A, 5'd8, 5'd0, 3'b111, 11'h400, 1'b1, 1'b0), 32'h700, 32'hABC0, 32'h3);
        // R11: 111 without the pattern, 110 pattern with nonzero x, sub 011
        step(1, mk(6'h3A, 5'd8, 5'd0, 3'b111, 11'h000, 1'b1, 1'b0), 32'h700, 32'hABC0, 32'h3);
        step(1, mk(6'h3A, 5'd8, 5'd2, 3'b110, 11'h400, 1'b0, 1'b0), 32'h700, 32'hABC0, 32'h3);
        step(1, mk(6'h3A, 5'd8, 5'd2, 3'b011, 11'h000, 1'b1, 1'b0), 32'h700, 32'hABC0, 32'h3);
        // R13: offset wrap
        step(1, mk(6'h3A, 5'd2, 5'd0, 3'b000, 11'h000, 1'b0, 1'b0), 32'hFFFF_FFFC, 32'h0, 32'h0);

        // Random mix weighted to branch opcodes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            int sel;
            w = $urandom;
            sel = $urandom_range(0, 9);
            if (sel < 2)      w[31:26] = 6'h38 + 6'($urandom_range(0, 1));
            else if (sel < 8) w[31:26] = 6'h3A;
            if ($urandom_range(0, 2) == 0) begin
                w[12:2] = ($urandom_range(0, 1) == 1) ? 11'h400 : 11'h000;
                w[0] = 1'b0;
                if ($urandom_range(0, 1) == 1) w[20:16] = 5'd0;
            end
            if ($urandom_range(0, 3) == 0) w[25:21] = 5'd0;
            step(($urandom_range(0, 7) != 0), w, $urandom, $urandom, $urandom);
        end
        step(0, 32'h0, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule